// File: doc/BRIEF.md
# Line-Synchronous B+ Drive Control

This block is the digital core of a switched-mode B+ supply driver that runs in step with horizontal deflection. A drive pulse starts on each rising edge of the horizontal drive signal. It ends when an external current-sense comparator reports that the sensed voltage has crossed the error-amplifier level. If no comparator event ends the pulse before the next line edge, that edge ends it instead. A new pulse then waits for the sense voltage to fall below a restart threshold.

In feed-forward operation the block also controls a discharge enable for the external timing capacitor. After a comparator-ended pulse, the enable stays on through the stop-level hold until the next line edge. After an edge-forced end, it stays on until the restart threshold is reached. In feedback operation the discharge enable is never asserted.

A protection inhibit floats the drive and clears the discharge enable. Every input is asynchronous and passes through a two-stage synchronizer. The analog amplifier, the comparator and the capacitor lie outside the block.

Top module: `bplus_drive_ctrl`

## Requirements
- R1: While reset is applied and right after it, `drive_n` is 1 (inactive) and `dis_en` is 0.
- R2: A rising edge on `hdrv` sets the drive (`drive_n` = 0) when the block is idle. Each input change reaches the outputs on the third rising clock edge after it appears at the pin: two synchronizer stages plus one output register.
- R3: While the drive is active, `sense_hi` = 1 ends the drive (`drive_n` returns to 1).
- R4: An `hdrv` rising edge that arrives while the drive is still active forces the drive off.
- R5: After an edge-forced end, `below_restart` = 1 sets the drive again with no line edge needed.
- R6: With `mode_ff` = 1 (feed-forward), a comparator-ended pulse raises `dis_en`. `dis_en` stays 1 after `at_stop` = 1, and the next `hdrv` rising edge clears it and sets the drive.
- R7: With `mode_ff` = 1, an edge-forced end raises `dis_en`. `below_restart` = 1 clears it and sets the drive.
- R8: With `mode_ff` = 0 (feedback), `dis_en` stays 0. This holds even when the mode drops to feedback during a discharge phase.
- R9: While `inhibit` = 1, `drive_n` = 1 and `dis_en` = 0, and line edges are ignored. After release, the drive resumes only at the next `hdrv` rising edge.
- R10: If `sense_hi` and an `hdrv` rising edge arrive in the same cycle while the drive is active, the comparator path wins: the block returns to waiting for a line edge, not for the restart threshold.
- R11: While the block waits for the restart threshold after an edge-forced end, further `hdrv` rising edges do not set the drive.
- R12: Only rising edges of `hdrv` set the drive. Holding `hdrv` high after a comparator-ended pulse does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdrv | input | 1 | Horizontal drive signal; rising edges mark line starts |
| sense_hi | input | 1 | Comparator flag: sense voltage above error-amplifier level |
| below_restart | input | 1 | Sense voltage below restart threshold |
| at_stop | input | 1 | Timing capacitor has reached the stop level |
| mode_ff | input | 1 | 1 = feed-forward operation, 0 = feedback operation |
| inhibit | input | 1 | Soft-start hold or protection: drive must float |
| drive_n | output | 1 | B+ drive, active low; 1 means floating |
| dis_en | output | 1 | Discharge enable for the external timing capacitor |

## Verification
The bench targets the corner cases where the choice between the comparator path and the line-edge path matters.

- A comparator event and a line edge in the same cycle must lead to line-edge waiting. A design that gave the forced path priority would hang until the restart flag and miss the next line.
- Line edges during restart waiting and a held-high `hdrv` must not set the drive. A design that sensed levels instead of edges would emit extra pulses.
- Discharge must survive the stop-level flag and end exactly at the line edge or at the restart flag. It must also never appear in feedback mode or under inhibit. A wrong design would drop the hold early or leave the capacitor clamped while the drive is on.
- Every output check is taken at the three-cycle latency. A missing or extra register would show up as an early or late output.

// File: rtl/bpd_pkg.sv
`timescale 1ns/1ps
package bpd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,  // waiting for a line edge
    ST_ON      = 3'd1,  // drive active
    ST_DISCH   = 3'd2,  // feed-forward discharge toward stop level
    ST_HOLD    = 3'd3,  // stop level held until the line edge
    ST_RESTART = 3'd4   // forced end, waiting for restart threshold
  } bpd_state_e;

  function automatic logic drive_active(bpd_state_e st);
    return st == ST_ON;
  endfunction

  function automatic logic discharge_active(bpd_state_e st, logic ff);
    return ff && (st == ST_DISCH || st == ST_HOLD || st == ST_RESTART);
  endfunction

  function automatic bpd_state_e after_compare(logic ff);
    return ff ? ST_DISCH : ST_IDLE;
  endfunction

endpackage

// File: rtl/bpd_sync.sv
`timescale 1ns/1ps
module bpd_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/bpd_edge.sv
`timescale 1ns/1ps
module bpd_edge #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;

endmodule

// File: rtl/bpd_core.sv
`timescale 1ns/1ps
module bpd_core
  import bpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_rise,
  input  logic sense,
  input  logic restart,
  input  logic stop,
  input  logic mode_ff,
  input  logic inhibit,
  output logic drive_n,
  output logic dis_en
);

  bpd_state_e st, nxt;

  always_comb begin
    nxt = st;
    if (inhibit) begin
      nxt = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:    if (line_rise) nxt = ST_ON;
        ST_ON: begin
          // comparator event has priority over a coincident line edge
          if (sense)          nxt = after_compare(mode_ff);
          else if (line_rise) nxt = ST_RESTART;
        end
        ST_DISCH: begin
          if (line_rise) nxt = ST_ON;
          else if (stop) nxt = ST_HOLD;
        end
        ST_HOLD:    if (line_rise) nxt = ST_ON;
        ST_RESTART: if (restart)   nxt = ST_ON;
        default:    nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      drive_n <= 1'b1;
      dis_en  <= 1'b0;
    end else begin
      st      <= nxt;
      drive_n <= !drive_active(nxt);
      dis_en  <= discharge_active(nxt, mode_ff);
    end
  end

endmodule

// File: rtl/bplus_drive_ctrl.sv
`timescale 1ns/1ps
module bplus_drive_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hdrv,
  input  logic sense_hi,
  input  logic below_restart,
  input  logic at_stop,
  input  logic mode_ff,
  input  logic inhibit,
  output logic drive_n,
  output logic dis_en
);

  localparam int N_IN    = 6;
  localparam int I_HDRV  = 0;
  localparam int I_SENSE = 1;
  localparam int I_RST   = 2;
  localparam int I_STOP  = 3;
  localparam int I_MODE  = 4;
  localparam int I_INH   = 5;

  logic [N_IN-1:0] raw_in, syn_in;
  logic line_rise, s_hdrv, s_sense, s_restart, s_stop, s_mode_ff, s_inhibit;

  assign raw_in = {inhibit, mode_ff, at_stop, below_restart, sense_hi, hdrv};

  bpd_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign s_hdrv    = syn_in[I_HDRV];
  assign s_sense   = syn_in[I_SENSE];
  assign s_restart = syn_in[I_RST];
  assign s_stop    = syn_in[I_STOP];
  assign s_mode_ff = syn_in[I_MODE];
  assign s_inhibit = syn_in[I_INH];

  bpd_edge #(.WIDTH(1)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(s_hdrv), .rise(line_rise)
  );

  bpd_core u_core (
    .clk(clk), .rst_n(rst_n),
    .line_rise(line_rise), .sense(s_sense), .restart(s_restart),
    .stop(s_stop), .mode_ff(s_mode_ff), .inhibit(s_inhibit),
    .drive_n(drive_n), .dis_en(dis_en)
  );

endmodule

// File: rtl/bpd_checker.sv
`timescale 1ns/1ps
module bpd_checker (
  input logic clk,
  input logic rst_n,
  input logic drive_n,
  input logic dis_en,
  input logic line_rise,
  input logic s_sense,
  input logic s_restart,
  input logic s_inhibit,
  input logic s_mode_ff
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (drive_n && !dis_en)); // R1
  AST_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_n) |-> $past(line_rise || s_restart)); // R2
  AST_COMPARE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_n && s_sense) |=> drive_n); // R3
  AST_EDGE_FORCES_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_n && line_rise) |=> drive_n); // R4
  AST_NO_DISCHARGE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    !(!drive_n && dis_en)); // R6
  AST_FEEDBACK_NO_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    !s_mode_ff |=> !dis_en); // R8
  AST_INHIBIT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    s_inhibit |=> (drive_n && !dis_en)); // R9

endmodule

bind bplus_drive_ctrl bpd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .drive_n(drive_n), .dis_en(dis_en),
  .line_rise(line_rise), .s_sense(s_sense), .s_restart(s_restart),
  .s_inhibit(s_inhibit), .s_mode_ff(s_mode_ff)
);

// File: tb/sim_bplus_drive_ctrl.sv
`timescale 1ns/1ps
module sim_bplus_drive_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdrv = 0, sense_hi = 0, below_restart = 0, at_stop = 0, mode_ff = 0, inhibit = 0;
  logic drive_n, dis_en;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bplus_drive_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hdrv(hdrv), .sense_hi(sense_hi),
    .below_restart(below_restart), .at_stop(at_stop), .mode_ff(mode_ff),
    .inhibit(inhibit), .drive_n(drive_n), .dis_en(dis_en)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // pin change then full three-cycle latency
  task automatic line_pulse();
    hdrv = 1; step(3);
    hdrv = 0; step(3);
  endtask

  task automatic t_reset();
    check("R1", "drive_n in reset", drive_n, 1'b1);
    check("R1", "dis_en in reset", dis_en, 1'b0);
    rst_n = 1; step(2);
    check("R1", "drive_n after reset", drive_n, 1'b1);
  endtask

  task automatic t_set_latency();
    hdrv = 1; step(2);
    check("R2", "drive_n before latency", drive_n, 1'b1);
    step(1);
    check("R2", "drive_n set by line edge", drive_n, 1'b0);
    hdrv = 0; step(3);
  endtask

  task automatic t_compare_fb();
    sense_hi = 1; step(3);
    check("R3", "drive_n after comparator", drive_n, 1'b1);
    check("R8", "dis_en in feedback", dis_en, 1'b0);
    sense_hi = 0; step(3);
    check("R3", "drive_n stays off", drive_n, 1'b1);
  endtask

  task automatic t_level_only();
    hdrv = 1; step(3);
    check("R2", "drive_n set again", drive_n, 1'b0);
    sense_hi = 1; step(3);
    sense_hi = 0; step(3);
    check("R12", "held hdrv does not set", drive_n, 1'b1);
    hdrv = 0; step(3);
  endtask

  task automatic t_forced_restart();
    line_pulse();
    check("R2", "drive on before forced end", drive_n, 1'b0);
    hdrv = 1; step(3);
    check("R4", "line edge forces end", drive_n, 1'b1);
    hdrv = 0; step(3);
    line_pulse();
    check("R11", "edge ignored while awaiting restart", drive_n, 1'b1);
    below_restart = 1; step(3);
    check("R5", "restart flag sets drive", drive_n, 1'b0);
    below_restart = 0; step(3);
  endtask

  task automatic t_coincident();
    hdrv = 1; sense_hi = 1; step(3);
    check("R10", "coincident events end drive", drive_n, 1'b1);
    hdrv = 0; sense_hi = 0; step(3);
    hdrv = 1; step(3);
    check("R10", "next edge sets after coincident", drive_n, 1'b0);
    hdrv = 0; step(3);
  endtask

  task automatic t_ff_compare();
    mode_ff = 1; step(3);
    sense_hi = 1; step(3);
    check("R6", "drive off after comparator", drive_n, 1'b1);
    check("R6", "discharge on after comparator", dis_en, 1'b1);
    sense_hi = 0; at_stop = 1; step(3);
    check("R6", "discharge held past stop", dis_en, 1'b1);
    at_stop = 0; hdrv = 1; step(3);
    check("R6", "line edge clears discharge", dis_en, 1'b0);
    check("R6", "line edge sets drive", drive_n, 1'b0);
    hdrv = 0; step(3);
  endtask

  task automatic t_ff_forced();
    hdrv = 1; step(3);
    check("R7", "forced end drive off", drive_n, 1'b1);
    check("R7", "forced end discharge on", dis_en, 1'b1);
    hdrv = 0; step(3);
    below_restart = 1; step(3);
    check("R7", "restart clears discharge", dis_en, 1'b0);
    check("R7", "restart sets drive", drive_n, 1'b0);
    below_restart = 0; step(3);
  endtask

  task automatic t_inhibit();
    inhibit = 1; step(3);
    check("R9", "inhibit floats drive", drive_n, 1'b1);
    check("R9", "inhibit clears discharge", dis_en, 1'b0);
    hdrv = 1; step(3);
    check("R9", "edge ignored under inhibit", drive_n, 1'b1);
    hdrv = 0; step(3);
    inhibit = 0; step(3);
    check("R9", "no drive until next edge", drive_n, 1'b1);
    hdrv = 1; step(3);
    check("R9", "edge after release sets", drive_n, 1'b0);
    hdrv = 0; step(3);
  endtask

  task automatic t_mode_drop();
    sense_hi = 1; step(3);
    check("R6", "discharge on before mode drop", dis_en, 1'b1);
    sense_hi = 0; mode_ff = 0; step(3);
    check("R8", "mode drop clears discharge", dis_en, 1'b0);
  endtask

  initial begin
    step(3);
    t_reset();
    t_set_latency();
    t_compare_fb();
    t_level_only();
    t_forced_restart();
    t_coincident();
    t_ff_compare();
    t_ff_forced();
    t_inhibit();
    t_mode_drop();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hang, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule